// File: doc/BRIEF.md
# Serial Flash Read Burst Sequencer

This block sequences reads for a memory-mapped serial flash controller. A requester presents an address with a valid/ready handshake. For each accepted read the sequencer asks an abstract transfer engine for a run of 64-bit data units and drives the active-low chip select for the flash device. The shifting of serial bits and the cache array are outside the block. The engine is a request/acknowledge pair, and the cache is reached through an enable level and a one-cycle invalidate pulse.

A single 32-bit control word sets the behaviour. It holds a burst enable, a 4-bit burst length, a chip-select hold policy, and two strobes that clear themselves: one releases the chip select and the other flushes the cache. With the hold policy, the chip select stays low across bursts whose addresses run on from each other. The device is then deselected only when a read jumps elsewhere or software asks for it. A status bit in the readback shows whether the chip select is released. Software polls it after a release request.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset the chip select is released (cs_n = 1), rd_ready is 1, cache_flush is 0 and the readback word is 0x0001_0000 (bit 16 is the released status).
- R2: With burst enable (write bit 0) at 0, each read fetches exactly one unit at the request address, and the chip select is released once it ends. The length field is ignored in this case.
- R3: With burst enable at 1, a read fetches L+1 units, where L is the length field (write bits 7:4). The units are fetched at the request address plus 8 times k, for k counting from 0.
- R4: With burst enable at 1 and the hold policy (write bit 1) at 0, the chip select is released when the burst ends. It is also released within two cycles of the hold policy being switched off while it is held.
- R5: With burst enable and hold both at 1, the chip select stays low after a burst. A following read at the last unit's address plus 8 starts without releasing it.
- R6: In hold mode, a read whose address does not follow on releases the chip select for one cycle before its burst begins.
- R7: Writing 1 to bit 9 while idle, with burst enable and hold both at 1, releases a held chip select. The same write made during a transfer has no effect. Bit 9 reads back as 0.
- R8: Writing 1 to bit 8 while idle produces exactly one cycle of cache_flush. The same write during a transfer produces none. Bit 8 reads back as 0.
- R9: Writes to the burst enable, hold and length fields are ignored while a transfer is in progress.
- R10: All bits other than 0, 1, 7:4 and 16 read back as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback with the released status |
| rd_valid | input | 1 | Read request valid |
| rd_addr | input | AW | Read request byte address |
| rd_ready | output | 1 | Sequencer idle and able to accept a read |
| eng_req | output | 1 | Transfer engine: fetch one unit at eng_addr |
| eng_addr | output | AW | Address of the unit being requested |
| eng_ack | input | 1 | Transfer engine: requested unit completed |
| cache_en | output | 1 | Read path goes through the cache (burst enabled) |
| cache_flush | output | 1 | One-cycle invalidate of all cache entries |
| cs_n | output | 1 | Active-low flash chip select |

## Verification
The assertions rely on two things. The control word changes only through reg_wr. The engine acknowledges only while eng_req is high. A single unit's acknowledge may come in the same cycle as the request or later. The stimulus holds rd_valid for exactly one cycle while rd_ready is high, and it never writes the control word in the cycle a read is accepted. The bench engine acknowledges every request at once, which keeps eng_ack within the engine contract. Writes during a transfer are timed to land while the sequencer is known to be busy.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_XFER = 2'd2
   } seq_state_t;

   localparam int CFG_EN_BIT    = 0;
   localparam int CFG_HOLD_BIT  = 1;
   localparam int CFG_LEN_LSB   = 4;
   localparam int CFG_FLUSH_BIT = 8;
   localparam int CFG_NEG_BIT   = 9;
   localparam int STAT_REL_BIT  = 16;
endpackage

// File: rtl/flash_rd_cfg.sv
module flash_rd_cfg #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      wdata,
   input  logic             idle,
   input  logic             cs_released,
   output logic             burst_en,
   output logic             hold_mode,
   output logic [LEN_W-1:0] burst_len,
   output logic             flush_pulse,
   output logic             negate_req,
   output logic [31:0]      rdata
);
   import flash_rd_pkg::*;

   generate
      if (LEN_W < 1 || LEN_W > 4) begin : g_bad_len
         $error("LEN_W must be 1..4");
      end
   endgenerate

   logic cfg_wr;
   logic unused_wdata;

   assign cfg_wr       = wr_en && idle;
   assign negate_req   = wr_en && wdata[CFG_NEG_BIT];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_en    <= 1'b0;
         hold_mode   <= 1'b0;
         burst_len   <= '0;
         flush_pulse <= 1'b0;
      end else begin
         flush_pulse <= cfg_wr && wdata[CFG_FLUSH_BIT];
         if (cfg_wr) begin
            burst_en  <= wdata[CFG_EN_BIT];
            hold_mode <= wdata[CFG_HOLD_BIT];
            burst_len <= wdata[CFG_LEN_LSB +: LEN_W];
         end
      end
   end

   always_comb begin
      rdata                           = '0;
      rdata[CFG_EN_BIT]               = burst_en;
      rdata[CFG_HOLD_BIT]             = hold_mode;
      rdata[CFG_LEN_LSB +: LEN_W]     = burst_len;
      rdata[STAT_REL_BIT]             = cs_released;
   end

   // R9: fields frozen while a transfer runs
   a_r9_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idle) |=> ($stable(burst_en) && $stable(hold_mode) && $stable(burst_len)));

   // R8: a flush pulse only follows an idle write
   a_r8_flush_from_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> $past(wr_en && idle));
endmodule

// File: rtl/flash_rd_burst.sv
module flash_rd_burst #(
   parameter int AW         = 32,
   parameter int LEN_W      = 4,
   parameter int UNIT_BYTES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    base_addr,
   input  logic [LEN_W-1:0] units_m1,
   input  logic             step,
   output logic [AW-1:0]    cur_addr,
   output logic             last
);
   localparam logic [AW-1:0] STEP = AW'(UNIT_BYTES);

   generate
      if (UNIT_BYTES < 1 || (UNIT_BYTES & (UNIT_BYTES - 1)) != 0) begin : g_bad_unit
         $error("UNIT_BYTES must be a power of two");
      end
   endgenerate

   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] lim;

   assign last = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         lim      <= '0;
         cur_addr <= '0;
      end else if (load) begin
         cnt      <= '0;
         lim      <= units_m1;
         cur_addr <= base_addr;
      end else if (step && !last) begin
         cnt      <= cnt + LEN_W'(1);
         cur_addr <= cur_addr + STEP;
      end
   end

   // R3: unit counter never passes the configured length
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
endmodule

// File: rtl/flash_rd_track.sv
module flash_rd_track #(
   parameter int AW         = 32,
   parameter int UNIT_BYTES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          update,
   input  logic [AW-1:0] last_addr,
   input  logic [AW-1:0] req_addr,
   output logic          hit,
   output logic          valid
);
   localparam logic [AW-1:0] STEP = AW'(UNIT_BYTES);

   logic [AW-1:0] next_addr;

   assign hit = valid && (req_addr == next_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         next_addr <= '0;
      end else if (clear) begin
         valid     <= 1'b0;
      end else if (update) begin
         valid     <= 1'b1;
         next_addr <= last_addr + STEP;
      end
   end
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq #(
   parameter int AW         = 32,
   parameter int LEN_W      = 4,
   parameter int UNIT_BYTES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_ready,
   output logic          eng_req,
   output logic [AW-1:0] eng_addr,
   input  logic          eng_ack,
   output logic          cache_en,
   output logic          cache_flush,
   output logic          cs_n
);
   import flash_rd_pkg::*;

   seq_state_t       state, state_d;
   logic             cs_q, cs_d;
   logic             idle, accept, hold_pol, unit_done, finish;
   logic             burst_en, hold_mode, negate_req, last;
   logic [LEN_W-1:0] burst_len, units_m1;
   logic             trk_hit, trk_valid;

   assign idle      = (state == ST_IDLE);
   assign accept    = rd_valid && idle;
   assign hold_pol  = burst_en && hold_mode;
   assign units_m1  = burst_en ? burst_len : '0;
   assign unit_done = (state == ST_XFER) && eng_ack;
   assign finish    = unit_done && last;

   assign rd_ready  = idle;
   assign eng_req   = (state == ST_XFER);
   assign cache_en  = burst_en;
   assign cs_n      = cs_q;

   flash_rd_cfg #(.LEN_W(LEN_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wdata      (reg_wdata),
      .idle       (idle),
      .cs_released(cs_q),
      .burst_en   (burst_en),
      .hold_mode  (hold_mode),
      .burst_len  (burst_len),
      .flush_pulse(cache_flush),
      .negate_req (negate_req),
      .rdata      (reg_rdata)
   );

   flash_rd_burst #(.AW(AW), .LEN_W(LEN_W), .UNIT_BYTES(UNIT_BYTES)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .base_addr(rd_addr),
      .units_m1 (units_m1),
      .step     (unit_done),
      .cur_addr (eng_addr),
      .last     (last)
   );

   flash_rd_track #(.AW(AW), .UNIT_BYTES(UNIT_BYTES)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cs_d),
      .update   (finish && hold_pol),
      .last_addr(eng_addr),
      .req_addr (rd_addr),
      .hit      (trk_hit),
      .valid    (trk_valid)
   );

   // cs_q = 1 means released (cs_n high)
   always_comb begin
      state_d = state;
      cs_d    = cs_q;
      unique case (state)
         ST_IDLE: begin
            if (accept) begin
               if (!cs_q && !(hold_pol && trk_hit)) begin
                  state_d = ST_GAP;
                  cs_d    = 1'b1;
               end else begin
                  state_d = ST_XFER;
                  cs_d    = 1'b0;
               end
            end else if (!cs_q && (!hold_pol || negate_req)) begin
               cs_d = 1'b1;
            end
         end
         ST_GAP: begin
            state_d = ST_XFER;
            cs_d    = 1'b0;
         end
         ST_XFER: begin
            if (finish) begin
               state_d = ST_IDLE;
               cs_d    = !hold_pol;
            end
         end
         default: begin
            state_d = ST_IDLE;
            cs_d    = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cs_q  <= 1'b1;
      end else begin
         state <= state_d;
         cs_q  <= cs_d;
      end
   end

   // R5: chip select is active during every unit fetch
   a_r5_cs_low_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER) |-> !cs_q);

   // R5: a held chip select always has a valid continuation address
   a_r5_held_has_track: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !cs_q) |-> trk_valid);

   // R4: release at burst end without the hold policy
   a_r4_release_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !hold_pol) |=> cs_q);

   // R6: the gap cycle has the chip select released
   a_r6_gap_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |-> cs_q);

   // R2: with burst disabled a single unit is loaded
   a_r2_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !burst_en) |=> last);
endmodule

// File: tb/tb_flash_rd_seq.sv
`timescale 1ns/1ps
module tb_flash_rd_seq;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_ready;
   logic          eng_req;
   logic [AW-1:0] eng_addr;
   logic          eng_ack;
   logic          cache_en;
   logic          cache_flush;
   logic          cs_n;

   int checks = 0;
   int fails  = 0;
   logic [AW-1:0] exp_q[$];
   bit   saw_rel = 1'b0;
   int   flush_cnt = 0;
   int   flush_run = 0;
   bit   m_en = 1'b0;
   int   m_len = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   assign eng_ack = eng_req;

   flash_rd_seq #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .eng_req(eng_req), .eng_addr(eng_addr),
      .eng_ack(eng_ack), .cache_en(cache_en), .cache_flush(cache_flush),
      .cs_n(cs_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // monitor: scoreboard of unit addresses, release and flush tracking
   always @(negedge clk) begin
      if (rst_n) begin
         if (eng_req && eng_ack) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R3 actual=0x%08h expected=none (extra unit)", eng_addr);
            end else begin
               logic [AW-1:0] e;
               e = exp_q.pop_front();
               if (eng_addr !== e) begin
                  fails++;
                  $display("FAIL R3 actual=0x%08h expected=0x%08h", eng_addr, e);
               end
            end
         end
         if (cs_n) saw_rel = 1'b1;
         if (cache_flush) begin
            flush_cnt++;
            flush_run++;
            if (flush_run > 1) begin
               checks++;
               fails++;
               $display("FAIL R8 actual=%0d expected=1 (pulse width)", flush_run);
            end
         end else begin
            flush_run = 0;
         end
      end
   end

   task automatic wr_reg(input logic [31:0] d);
      reg_wr    = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic start_read(input logic [AW-1:0] a);
      int n;
      n = m_en ? m_len + 1 : 1;
      for (int k = 0; k < n; k++) exp_q.push_back(a + AW'(8 * k));
      saw_rel  = 1'b0;
      rd_valid = 1'b1;
      rd_addr  = a;
      @(negedge clk);
      rd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!rd_ready) @(negedge clk);
      chk("R3 all units delivered", 32'(exp_q.size()), 32'd0);
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      start_read(a);
      wait_idle();
   endtask

   task automatic finish_sim();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_sim();
      end
   end

   initial begin
      int fc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cs_n", 32'(cs_n), 32'd1);
      chk("R1 rd_ready", 32'(rd_ready), 32'd1);
      chk("R1 cache_flush", 32'(cache_flush), 32'd0);
      chk("R1 readback", reg_rdata, 32'h0001_0000);

      // R10 reserved bits, burst off with length set
      wr_reg(32'hFFFF_FCF0);
      chk("R10 reserved read 0", reg_rdata, 32'h0001_00F0);
      m_en = 1'b0; m_len = 15;
      do_read(32'h0000_0100);
      chk("R2 cs released", 32'(cs_n), 32'd1);
      do_read(32'h0000_0208);
      chk("R2 cs released second", 32'(cs_n), 32'd1);

      // R3 / R4 bursts without hold
      wr_reg(32'h0000_0031);
      m_en = 1'b1; m_len = 3;
      chk("R3 readback", reg_rdata, 32'h0001_0031);
      do_read(32'h0000_1000);
      chk("R4 cs released after burst", 32'(cs_n), 32'd1);
      wr_reg(32'h0000_0001);
      m_len = 0;
      do_read(32'h0000_0040);
      chk("R4 cs released len0", 32'(cs_n), 32'd1);
      wr_reg(32'h0000_00F1);
      m_len = 15;
      do_read(32'h0000_8000);
      chk("R4 cs released len15", 32'(cs_n), 32'd1);

      // R5 hold across contiguous bursts
      wr_reg(32'h0000_0013);
      m_len = 1;
      do_read(32'h0000_2000);
      chk("R5 cs held", 32'(cs_n), 32'd0);
      chk("R5 status held", reg_rdata, 32'h0000_0013);
      do_read(32'h0000_2010);
      chk("R5 no release when contiguous", 32'(saw_rel), 32'd0);
      chk("R5 cs still held", 32'(cs_n), 32'd0);

      // R6 non-contiguous jump
      do_read(32'h0000_3000);
      chk("R6 release before jump", 32'(saw_rel), 32'd1);
      chk("R6 cs held after", 32'(cs_n), 32'd0);

      // R7 / R9 negate and config write during transfer ignored
      start_read(32'h0000_3010);
      wr_reg(32'h0000_0200);
      wait_idle();
      chk("R7 busy negate ignored", 32'(cs_n), 32'd0);
      chk("R9 busy write ignored", reg_rdata, 32'h0000_0013);

      // R8 flush during transfer ignored
      fc = flush_cnt;
      start_read(32'h0000_3020);
      wr_reg(32'h0000_0113);
      wait_idle();
      @(negedge clk);
      chk("R8 busy flush ignored", 32'(flush_cnt), 32'(fc));

      // R7 idle negate
      wr_reg(32'h0000_0213);
      chk("R7 cs released", 32'(cs_n), 32'd1);
      chk("R7 readback", reg_rdata, 32'h0001_0013);

      // R8 idle flush
      fc = flush_cnt;
      wr_reg(32'h0000_0113);
      @(negedge clk);
      chk("R8 one flush pulse", 32'(flush_cnt), 32'(fc + 1));
      chk("R8 readback", reg_rdata, 32'h0001_0013);

      // R4 hold switched off while held
      do_read(32'h0000_4000);
      chk("R5 held before switch", 32'(cs_n), 32'd0);
      wr_reg(32'h0000_0031);
      @(negedge clk);
      chk("R4 release on policy off", 32'(cs_n), 32'd1);
      chk("R4 readback", reg_rdata, 32'h0001_0031);

      done = 1'b1;
      finish_sim();
   end
endmodule